// File: doc/BRIEF.md
# SECDED Protected Synchronous FIFO

This block is a single-clock first-in first-out buffer. Before each word is stored, it gets a check code that can correct one bit error and detect two. Every write adds Hamming check bits and one overall parity bit to the data word, and the memory keeps the widened word. Every read decodes the word taken from memory. The block returns the repaired data together with two sticky-until-next-read flags. One flag says a single bit was repaired. The other says the word held an error the code cannot correct.

A fault-injection mask is XORed onto the memory output just ahead of the decoder. A test environment can use it to flip any chosen bits of the word being read without touching the stored copy. Tied to zero, the mask has no effect. Reads are registered: data and flags appear one cycle after an accepted read. Occupancy is reported through `full` and `empty`. The reset input is asynchronous and active-low. It is released synchronously through an internal two-stage synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `secded_fifo`

## Requirements
- R1: Each write stores the data word plus P Hamming check bits plus one overall parity bit. For DATA_W=32 this is P=6, 39 bits in total. Stored bit k (k = 0..DATA_W+P-1) is codeword position k+1: positions that are powers of two hold check bits and the others hold data bits, low data bit first. The top stored bit is the overall parity. With a zero fault mask, a read returns the written word with rd_error=0 and rd_corrected=0.
- R2: When exactly one bit of the word being read is flipped through fault_mask, the read returns the written word with rd_corrected=1 and rd_error=0. This applies to every bit position, including check bits and the overall parity bit.
- R3: When exactly two bits of the word being read are flipped, the read gives rd_error=1 and rd_corrected=0.
- R4: full and empty are never 1 at the same time.
- R5: Starting from empty, DEPTH writes with no reads set full to 1, and full stays 0 after the first DEPTH-1 of them.
- R6: Starting from full, DEPTH reads with no writes set empty to 1, and empty stays 0 before the last of them.
- R7: In the cycle after any write request, empty is 0.
- R8: Reads return words oldest first. A read accepted at a clock edge presents its data and flags right after that edge. A word written into an empty FIFO can be read on the very next cycle.
- R9: A write request while full is ignored: full stays 1 and the dropped word never appears on rd_data.
- R10: A read request while empty is ignored: empty stays 1, and rd_data, rd_error and rd_corrected keep their values.
- R11: A read and a write in the same cycle, with the FIFO neither full nor empty, leave full and empty unchanged and keep the word order.
- R12: After reset, empty=1, full=0, rd_data=0, rd_error=0 and rd_corrected=0.
- R13: fault_mask acts only on the word being read. A mask present during a write does not corrupt the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| fault_mask | input | DATA_W+P+1 | XOR mask applied to the memory output before decoding |
| rd_data | output | DATA_W | Decoded read data, registered |
| rd_error | output | 1 | Uncorrectable (double) error seen on the last read |
| rd_corrected | output | 1 | Single error repaired on the last read |
| full | output | 1 | No free entry |
| empty | output | 1 | No stored entry |

## Verification
The bench builds the block with DATA_W=32 and DEPTH=4. The 32-bit width gives the full 39-bit code, so a sweep can flip every single stored position, every adjacent pair and every pair with the overall parity bit. The shallow depth makes the full, overflow, wrap-around and drain-to-empty edges reachable within a few cycles of each test.

// File: rtl/secded_fifo_pkg.sv
package secded_fifo_pkg;

  // Number of Hamming check bits needed for a data word of width dw
  function automatic int hamming_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

endpackage

// File: rtl/secded_rst_sync.sv
module secded_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/secded_enc.sv
module secded_enc #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]  data_i,
  output logic [DATA_W+secded_fifo_pkg::hamming_bits(DATA_W):0] code_o
);
  localparam int P = secded_fifo_pkg::hamming_bits(DATA_W);
  localparam int N = DATA_W + P;

  logic [N:1] cw;

  always_comb begin
    int k;
    logic par;
    cw = '0;
    k  = 0;
    // scatter data bits to non-power-of-two positions
    for (int pos = 1; pos <= N; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        cw[pos] = data_i[k];
        k++;
      end
    end
    // each check bit covers the positions whose index has its bit set
    for (int i = 0; i < P; i++) begin
      par = 1'b0;
      for (int pos = 1; pos <= N; pos++) begin
        if (((pos >> i) & 1) == 1) par = par ^ cw[pos];
      end
      cw[1 << i] = par;
    end
    code_o = {^cw, cw};
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W+secded_fifo_pkg::hamming_bits(DATA_W):0] code_i,
  output logic [DATA_W-1:0] data_o,
  output logic              single_o,
  output logic              double_o
);
  localparam int P = secded_fifo_pkg::hamming_bits(DATA_W);
  localparam int N = DATA_W + P;

  logic [N:1]   cw;
  logic [N:1]   fixed;
  logic [P-1:0] syn;
  logic         par_odd;

  always_comb begin
    int k;
    cw      = code_i[N-1:0];
    par_odd = ^code_i;
    for (int i = 0; i < P; i++) begin
      syn[i] = 1'b0;
      for (int pos = 1; pos <= N; pos++) begin
        if (((pos >> i) & 1) == 1) syn[i] = syn[i] ^ cw[pos];
      end
    end

    fixed    = cw;
    single_o = 1'b0;
    double_o = 1'b0;
    if (syn != '0) begin
      if (par_odd && (int'(syn) <= N)) begin
        single_o = 1'b1;
        for (int pos = 1; pos <= N; pos++) begin
          if (int'(syn) == pos) fixed[pos] = ~fixed[pos];
        end
      end else begin
        double_o = 1'b1;
      end
    end else if (par_odd) begin
      single_o = 1'b1;  // only the overall parity bit was hit
    end

    data_o = '0;
    k      = 0;
    for (int pos = 1; pos <= N; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        data_o[k] = fixed[pos];
        k++;
      end
    end
  end
endmodule

// File: rtl/secded_fifo_ctrl.sv
module secded_fifo_ctrl #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  output logic                     wr_fire,
  output logic                     rd_fire,
  output logic [$clog2(DEPTH)-1:0] wr_ptr,
  output logic [$clog2(DEPTH)-1:0] rd_ptr,
  output logic                     full,
  output logic                     empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP   = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign full    = (cnt_q == CAP);
  assign empty   = (cnt_q == '0);
  assign wr_fire = wr_en && !full;
  assign rd_fire = rd_en && !empty;
  assign wr_ptr  = wr_ptr_q;
  assign rd_ptr  = rd_ptr_q;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (wr_fire) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    if (rd_fire) rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    if (wr_fire && !rd_fire)      cnt_d = cnt_q + 1'b1;
    else if (rd_fire && !wr_fire) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (wr_fire || rd_fire) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assert_never_full_and_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  assert_write_clears_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !empty);

  assert_full_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> full && $stable(wr_ptr_q));

  assert_empty_read_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> $stable(rd_ptr_q));

  assert_same_cycle_rw_keeps_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && !full && !empty) |=> !full && !empty);
endmodule

// File: rtl/secded_fifo.sv
module secded_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [DATA_W+secded_fifo_pkg::hamming_bits(DATA_W):0] fault_mask,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_error,
  output logic                rd_corrected,
  output logic                full,
  output logic                empty
);
  localparam int P       = secded_fifo_pkg::hamming_bits(DATA_W);
  localparam int STORE_W = DATA_W + P + 1;
  localparam int PTR_W   = $clog2(DEPTH);

  logic               rst_n_s;
  logic               wr_fire, rd_fire;
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [STORE_W-1:0] enc_code, raw_word, dec_in;
  logic [DATA_W-1:0]  dec_data;
  logic               dec_single, dec_double;
  logic [STORE_W-1:0] mem [DEPTH];

  logic [DATA_W-1:0]  rd_data_q, rd_data_d;
  logic               err_q, err_d, cor_q, cor_d;

  secded_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  secded_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .full    (full),
    .empty   (empty)
  );

  secded_enc #(.DATA_W(DATA_W)) u_enc (
    .data_i (wr_data),
    .code_o (enc_code)
  );

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr] <= enc_code;
  end

  assign raw_word = mem[rd_ptr];
  assign dec_in   = raw_word ^ fault_mask;

  secded_dec #(.DATA_W(DATA_W)) u_dec (
    .code_i   (dec_in),
    .data_o   (dec_data),
    .single_o (dec_single),
    .double_o (dec_double)
  );

  always_comb begin
    rd_data_d = rd_data_q;
    err_d     = err_q;
    cor_d     = cor_q;
    if (rd_fire) begin
      rd_data_d = dec_data;
      err_d     = dec_double;
      cor_d     = dec_single;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rd_data_q <= '0;
      err_q     <= 1'b0;
      cor_q     <= 1'b0;
    end else if (rd_fire) begin
      rd_data_q <= rd_data_d;
      err_q     <= err_d;
      cor_q     <= cor_d;
    end
  end

  assign rd_data      = rd_data_q;
  assign rd_error     = err_q;
  assign rd_corrected = cor_q;

  assert_clean_read_no_flags_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_fire && fault_mask == '0) |=> !rd_error && !rd_corrected);

  assert_single_flip_corrected_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_fire && $countones(fault_mask) == 1) |=> rd_corrected && !rd_error);

  assert_double_flip_flagged_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_fire && $countones(fault_mask) == 2) |=> rd_error && !rd_corrected);

  assert_empty_read_holds_output_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && empty) |=> $stable(rd_data) && $stable(rd_error) && $stable(rd_corrected));
endmodule

// File: tb/secded_fifo_tb.sv
`timescale 1ns/1ps
module secded_fifo_tb_top;
  localparam int DATA_W  = 32;
  localparam int DEPTH   = 4;
  localparam int STORE_W = DATA_W + secded_fifo_pkg::hamming_bits(DATA_W) + 1;

  typedef struct packed {
    logic [DATA_W-1:0]  data;
    logic [STORE_W-1:0] mask;
    logic [1:0]         kind;  // 0 clean, 1 single flip, 2 double flip
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0000, 39'h0,           2'd0},
    '{32'hFFFF_FFFF, 39'h0,           2'd0},
    '{32'h1234_5678, 39'h0,           2'd0},
    '{32'hCAFE_F00D, 39'h1,           2'd1},
    '{32'h8000_0001, 39'h40_0000_0000, 2'd1},
    '{32'h0F0F_0F0F, 39'h00_0000_0080, 2'd1},
    '{32'hA5A5_A5A5, 39'h00_0020_0000, 2'd1},
    '{32'h5555_AAAA, 39'h3,           2'd2},
    '{32'h0000_FFFF, 39'h00_0010_0008, 2'd2},
    '{32'hDEAD_0042, 39'h40_0000_0400, 2'd2}
  };

  logic                clk;
  logic                rst_n;
  logic                wr_en, rd_en;
  logic [DATA_W-1:0]   wr_data;
  logic [STORE_W-1:0]  fault_mask;
  logic [DATA_W-1:0]   rd_data;
  logic                rd_error, rd_corrected, full, empty;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  secded_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_en        (rd_en),
    .fault_mask   (fault_mask),
    .rd_data      (rd_data),
    .rd_error     (rd_error),
    .rd_corrected (rd_corrected),
    .full         (full),
    .empty        (empty)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write a word, read it back on the next cycle with a mask, check result
  task automatic pair(input logic [DATA_W-1:0] d, input logic [STORE_W-1:0] m,
                      input int kind, input string req);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    chk(empty == 1'b0, "R7 empty after write", 64'(empty), 64'd0);
    wr_en = 1'b0; rd_en = 1'b1; fault_mask = m;
    @(negedge clk);
    rd_en = 1'b0; fault_mask = '0;
    if (kind == 2) begin
      chk(rd_error == 1'b1 && rd_corrected == 1'b0, req,
          64'({rd_error, rd_corrected}), 64'b10);
    end else begin
      chk(rd_data == d, req, 64'(rd_data), 64'(d));
      chk(rd_error == 1'b0 && rd_corrected == 1'(kind == 1), req,
          64'({rd_error, rd_corrected}), 64'({1'b0, 1'(kind == 1)}));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] last;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0; fault_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    chk(empty == 1'b1 && full == 1'b0, "R12 occupancy after reset", 64'({full, empty}), 64'b01);
    chk(rd_data == '0 && !rd_error && !rd_corrected, "R12 outputs after reset",
        64'({rd_error, rd_corrected, rd_data}), 64'd0);

    // vector table: R1 clean, R2 single, R3 double, R8 next-cycle read
    for (int v = 0; v < NVEC; v++) begin
      pair(VECS[v].data, VECS[v].mask, int'(VECS[v].kind),
           VECS[v].kind == 2'd0 ? "R1 clean read / R8" :
           VECS[v].kind == 2'd1 ? "R2 single flip" : "R3 double flip");
    end

    // R2 every single stored bit
    for (int b = 0; b < STORE_W; b++)
      pair(32'h3C96_0000 ^ DATA_W'(b * 32'h0101_0107), STORE_W'(1) << b, 1, "R2 single sweep");

    // R3 adjacent pairs and pairs with the overall parity bit
    for (int b = 0; b < STORE_W - 1; b++) begin
      pair(32'h6A00_11C3 + DATA_W'(b), STORE_W'(3) << b, 2, "R3 adjacent pair");
      pair(32'h9F31_0E00 - DATA_W'(b), (STORE_W'(1) << b) | (STORE_W'(1) << (STORE_W - 1)),
           2, "R3 pair with overall parity");
    end

    // R13 mask during write does not corrupt the stored word
    wr_en = 1'b1; wr_data = 32'h1357_9BDF; fault_mask = STORE_W'(5);
    @(negedge clk);
    wr_en = 1'b0; fault_mask = '0; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_data == 32'h1357_9BDF && !rd_error && !rd_corrected, "R13 mask at write",
        64'(rd_data), 64'h1357_9BDF);

    // R5 fill
    for (int i = 0; i < DEPTH; i++) begin
      wr_en = 1'b1; wr_data = 32'hA000_0000 + DATA_W'(i);
      @(negedge clk);
      chk(full == 1'(i == DEPTH - 1), "R5 full after DEPTH writes", 64'(full), 64'(i == DEPTH - 1));
      chk(!(full && empty), "R4 not full and empty", 64'({full, empty}), 64'b10);
    end
    // R9 write while full
    wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    wr_en = 1'b0;
    chk(full == 1'b1, "R9 full stays after dropped write", 64'(full), 64'd1);

    // R6 drain, R8 order, R9 dropped word absent
    for (int i = 0; i < DEPTH; i++) begin
      rd_en = 1'b1;
      @(negedge clk);
      chk(rd_data == 32'hA000_0000 + DATA_W'(i), "R8 oldest first / R9",
          64'(rd_data), 64'(32'hA000_0000 + DATA_W'(i)));
      chk(empty == 1'(i == DEPTH - 1), "R6 empty after DEPTH reads", 64'(empty), 64'(i == DEPTH - 1));
    end
    // R10 read while empty
    last = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_data == last && empty && !rd_error && !rd_corrected, "R10 empty read ignored",
        64'(rd_data), 64'(last));

    // R11 simultaneous read and write
    wr_en = 1'b1; wr_data = 32'hB000_0001;
    @(negedge clk);
    wr_data = 32'hB000_0002;
    @(negedge clk);
    wr_data = 32'hB000_0003; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk(rd_data == 32'hB000_0001, "R11 read during write", 64'(rd_data), 64'hB000_0001);
    chk(!full && !empty, "R11 level kept", 64'({full, empty}), 64'b00);
    rd_en = 1'b1;
    @(negedge clk);
    chk(rd_data == 32'hB000_0002, "R11 order kept", 64'(rd_data), 64'hB000_0002);
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_data == 32'hB000_0003 && empty, "R11 last word", 64'(rd_data), 64'hB000_0003);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule